// File: doc/BRIEF.md
# Ethernet Test Frame Source

This block produces a burst of well-formed (or deliberately short) Ethernet frames on a byte-wide transmit interface made of a data byte, an enable and an error line, one byte per clock. It is meant to drive the receive side of a MAC under test. A single start pulse captures the run settings and launches the burst: a programmed number of frames, each carrying a preamble, a start delimiter, destination and source addresses, an optional VLAN tag, a length field, an incrementing payload, optional zero padding and a correct CRC-32 frame check sequence.

The payload length of the first frame is programmable. Each later frame adds a fixed step, and when the sum would pass a ceiling the length restarts from zero, so a long run sweeps lengths repeatedly. Frames are separated by a programmable number of idle byte times. A pause request, when pause reaction is enabled, holds the generator between frames: the frame in flight and its gap always finish first. A one-cycle done pulse marks the end of the burst.

The byte interface follows the usual media-independent convention: it has no ready line and the receiver cannot apply back-pressure. The enable stays high for every byte of a frame, from the first preamble byte to the last check byte, and low for every idle byte time. The only throttle is the pause request, which acts on frame boundaries.

Top module: `eth_test_frame_gen`

## Requirements
- R1: After reset and whenever no burst is running, `gm_en`, `gm_err` and `done` are low; `gm_err` is never raised.
- R2: A start pulse seen while idle produces exactly `frame_count` frames (each a contiguous run of `gm_en` high); with `frame_count` equal to 0 no frame is sent.
- R3: Every frame begins with seven bytes of 0x55 followed by one byte of 0xD5.
- R4: After the delimiter come `dst_addr` then `src_addr`, each most significant byte first; when `vlan_en` is set the four bytes 0x81, 0x00, `vlan_tci[15:8]`, `vlan_tci[7:0]` follow; then a two-byte field holding the payload length, high byte first.
- R5: Payload byte k (counting from 0) has the value k modulo 256.
- R6: The first frame's payload length is `len_first`; each following frame uses previous plus `len_step`, or 0 when that sum is greater than `len_max`.
- R7: With `pad_en` set, zero bytes follow the payload until the bytes from the destination address through the pad number 60 (64 with the check sequence); with `pad_en` clear no pad is added and short frames go out undersized.
- R8: The last four bytes of a frame are the CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, result inverted) over destination address through pad, least significant byte first.
- R9: Between two frames of a burst `gm_en` is low for exactly `gap_bytes` cycles (a value of 0 acts as 1).
- R10: With `pause_en` set, a `pause_req` seen during a frame or its gap lets that frame and gap complete, then no preamble starts while `pause_req` stays high; the next frame begins after `pause_req` falls.
- R11: With `pause_en` clear, `pause_req` has no effect on frame timing.
- R12: `done` is high for exactly one cycle: the cycle in which the final check byte of the burst is on `gm_data`, or, for a zero frame count, the cycle after the start pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a burst; sampled only while idle |
| frame_count | input | 16 | Number of frames in the burst |
| len_first | input | 11 | Payload length of the first frame |
| len_step | input | 11 | Payload length increment per frame |
| len_max | input | 11 | Payload length ceiling before wrap to zero |
| gap_bytes | input | 8 | Idle byte times between frames |
| pad_en | input | 1 | Pad short frames to minimum size |
| vlan_en | input | 1 | Insert a VLAN tag in every frame |
| vlan_tci | input | 16 | Tag control field of the VLAN tag |
| pause_en | input | 1 | React to pause requests |
| pause_req | input | 1 | Request to hold before the next frame |
| dst_addr | input | 48 | Destination address |
| src_addr | input | 48 | Source address |
| gm_data | output | 8 | Transmit byte |
| gm_en | output | 1 | Transmit enable, high during frame bytes |
| gm_err | output | 1 | Transmit error, held low |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
All outputs are registered: a start pulse sampled at one rising edge puts the first preamble byte on the pins after the following edge, and a zero-count start raises `done` right after the sampling edge. The bench drives inputs on falling edges and records every output on falling edges, so each byte, gap length and `done` cycle is captured half a cycle after the edge that produced it. Frame contents are compared byte by byte against images built in the bench from the requirements, the gap is the count of sampled low-enable cycles between runs, and `done` must land on the same sampled cycle as the last enabled byte. For pause, the release of `pause_req` is timestamped and the next frame's first byte must fall strictly later.

// File: rtl/eth_tfg_pkg.sv
package eth_tfg_pkg;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam int          PRE_LAST    = 7;
  localparam int          HDR_PLAIN   = 14;
  localparam int          HDR_TAGGED  = 18;
  localparam int          MIN_BODY    = 60;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_BODY,
    ST_FCS,
    ST_GAP,
    ST_HOLD
  } tfg_state_e;

  // Reflected CRC-32 update over one byte, LSB first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/tfg_crc32.sv
module tfg_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import eth_tfg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (clear)  crc_q <= '1;
    else if (en)     crc_q <= crc32_byte(crc_q, din);
  end
endmodule

// File: rtl/tfg_len_seq.sv
module tfg_len_seq #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] first_len,
  input  logic [LEN_W-1:0] step,
  input  logic [LEN_W-1:0] ceiling,
  input  logic             advance,
  output logic [LEN_W-1:0] len_q
);
  logic [LEN_W:0] sum;
  logic [LEN_W-1:0] nxt;

  always_comb begin
    sum = {1'b0, len_q} + {1'b0, step};
    nxt = (sum > {1'b0, ceiling}) ? '0 : sum[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (load)    len_q <= first_len;
    else if (advance) len_q <= nxt;
  end
endmodule

// File: rtl/tfg_byte_sel.sv
module tfg_byte_sel #(
  parameter int LEN_W = 11,
  parameter int IDX_W = 12
) (
  input  eth_tfg_pkg::tfg_state_e st,
  input  logic [IDX_W-1:0]        idx,
  input  logic [47:0]             da,
  input  logic [47:0]             sa,
  input  logic                    vlan,
  input  logic [15:0]             tci,
  input  logic                    pad,
  input  logic [LEN_W-1:0]        plen,
  input  logic [31:0]             crc,
  output logic [7:0]              tx_byte,
  output logic [IDX_W-1:0]        body_len
);
  import eth_tfg_pkg::*;

  int          k, hdr, dend, blen;
  logic [15:0] p16;
  logic [31:0] fcs;

  always_comb begin
    k    = int'(idx);
    hdr  = vlan ? HDR_TAGGED : HDR_PLAIN;
    dend = hdr + int'(plen);
    blen = (pad && dend < MIN_BODY) ? MIN_BODY : dend;
    body_len = IDX_W'(blen);
    p16  = 16'(plen);
    fcs  = ~crc;
    tx_byte = 8'h00;
    case (st)
      ST_PRE:  tx_byte = (k == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
      ST_BODY: begin
        if (k < 6)                    tx_byte = da[8*(5-k) +: 8];
        else if (k < 12)              tx_byte = sa[8*(11-k) +: 8];
        else if (vlan && k == 12)     tx_byte = 8'h81;
        else if (vlan && k == 13)     tx_byte = 8'h00;
        else if (vlan && k == 14)     tx_byte = tci[15:8];
        else if (vlan && k == 15)     tx_byte = tci[7:0];
        else if (k == hdr - 2)        tx_byte = p16[15:8];
        else if (k == hdr - 1)        tx_byte = p16[7:0];
        else if (k < dend)            tx_byte = 8'(k - hdr);
        else                          tx_byte = 8'h00;
      end
      ST_FCS:  tx_byte = fcs[8*(k%4) +: 8];
      default: tx_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/eth_test_frame_gen.sv
module eth_test_frame_gen #(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frame_count,
  input  logic [LEN_W-1:0] len_first,
  input  logic [LEN_W-1:0] len_step,
  input  logic [LEN_W-1:0] len_max,
  input  logic [GAP_W-1:0] gap_bytes,
  input  logic             pad_en,
  input  logic             vlan_en,
  input  logic [15:0]      vlan_tci,
  input  logic             pause_en,
  input  logic             pause_req,
  input  logic [47:0]      dst_addr,
  input  logic [47:0]      src_addr,
  output logic [7:0]       gm_data,
  output logic             gm_en,
  output logic             gm_err,
  output logic             done
);
  import eth_tfg_pkg::*;

  localparam int IDX_W = LEN_W + 1;

  tfg_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] gap_cnt, gap_len;
  logic [CNT_W-1:0] remain;
  logic             pend;

  logic [47:0]      da_r, sa_r;
  logic [15:0]      tci_r;
  logic             vlan_r, pad_r;
  logic [GAP_W-1:0] ipg_r;

  logic [LEN_W-1:0] plen;
  logic [31:0]      crc_q;
  logic [7:0]       cur_byte;
  logic [IDX_W-1:0] body_len;
  logic             launch, frame_end, tx_on;

  always_comb begin
    launch    = (state == ST_IDLE) && start;
    frame_end = (state == ST_FCS) && (idx == IDX_W'(3));
    tx_on     = (state == ST_PRE) || (state == ST_BODY) || (state == ST_FCS);
    gap_len   = (ipg_r == '0) ? GAP_W'(1) : ipg_r;
  end

  tfg_len_seq #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .first_len(len_first), .step(len_step), .ceiling(len_max),
    .advance(frame_end), .len_q(plen)
  );

  tfg_byte_sel #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_sel (
    .st(state), .idx(idx), .da(da_r), .sa(sa_r), .vlan(vlan_r),
    .tci(tci_r), .pad(pad_r), .plen(plen), .crc(crc_q),
    .tx_byte(cur_byte), .body_len(body_len)
  );

  tfg_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_PRE),
    .en(state == ST_BODY), .din(cur_byte), .crc_q(crc_q)
  );

  assign gm_err = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      gap_cnt <= '0;
      remain  <= '0;
      pend    <= 1'b0;
      da_r    <= '0;
      sa_r    <= '0;
      tci_r   <= '0;
      vlan_r  <= 1'b0;
      pad_r   <= 1'b0;
      ipg_r   <= '0;
      gm_data <= '0;
      gm_en   <= 1'b0;
      done    <= 1'b0;
    end else begin
      gm_en   <= tx_on;
      gm_data <= tx_on ? cur_byte : 8'h00;
      done    <= 1'b0;

      if (state == ST_IDLE || state == ST_HOLD) pend <= 1'b0;
      else if (pause_en && pause_req)           pend <= 1'b1;

      case (state)
        ST_IDLE: if (start) begin
          da_r   <= dst_addr;
          sa_r   <= src_addr;
          tci_r  <= vlan_tci;
          vlan_r <= vlan_en;
          pad_r  <= pad_en;
          ipg_r  <= gap_bytes;
          remain <= frame_count;
          idx    <= '0;
          if (frame_count == '0) done  <= 1'b1;
          else                   state <= ST_PRE;
        end
        ST_PRE: begin
          if (idx == IDX_W'(PRE_LAST)) begin
            state <= ST_BODY;
            idx   <= '0;
          end else idx <= idx + 1'b1;
        end
        ST_BODY: begin
          if (idx == body_len - 1'b1) begin
            state <= ST_FCS;
            idx   <= '0;
          end else idx <= idx + 1'b1;
        end
        ST_FCS: begin
          if (idx == IDX_W'(3)) begin
            idx    <= '0;
            remain <= remain - 1'b1;
            gap_cnt <= '0;
            if (remain == CNT_W'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else state <= ST_GAP;
          end else idx <= idx + 1'b1;
        end
        ST_GAP: begin
          if (gap_cnt == gap_len - 1'b1) begin
            if (pause_en && (pend || pause_req)) state <= ST_HOLD;
            else                                 state <= ST_PRE;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
        ST_HOLD: if (!pause_req) state <= ST_PRE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tfg_chk.sv
module tfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gm_en,
  input logic [7:0] gm_data,
  input logic       done,
  input logic       pad_cfg
);
  logic [15:0] en_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_run <= '0;
    else if (gm_en) en_run <= en_run + 1'b1;
    else            en_run <= '0;
  end

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !gm_en);

  // R3
  pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gm_en) |-> gm_data == 8'h55);

  // R4
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gm_en) |-> en_run >= 16'd26);

  // R7
  pad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gm_en) && pad_cfg) |-> en_run >= 16'd72);
endmodule

bind eth_test_frame_gen tfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gm_en(gm_en), .gm_data(gm_data),
  .done(done), .pad_cfg(pad_r)
);

// File: tb/tb_eth_test_frame_gen.sv
`timescale 1ns/1ps
module tb_eth_test_frame_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] frame_count = '0;
  logic [10:0] len_first = '0, len_step = '0, len_max = '0;
  logic [7:0]  gap_bytes = '0;
  logic        pad_en = 1'b0, vlan_en = 1'b0, pause_en = 1'b0, pause_req = 1'b0;
  logic [15:0] vlan_tci = '0;
  logic [47:0] dst_addr = 48'hA1B2C3D4E5F6;
  logic [47:0] src_addr = 48'h021122334455;
  logic [7:0]  gm_data;
  logic        gm_en, gm_err, done;

  always #5 clk = ~clk;

  eth_test_frame_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_count(frame_count),
    .len_first(len_first), .len_step(len_step), .len_max(len_max),
    .gap_bytes(gap_bytes), .pad_en(pad_en), .vlan_en(vlan_en),
    .vlan_tci(vlan_tci), .pause_en(pause_en), .pause_req(pause_req),
    .dst_addr(dst_addr), .src_addr(src_addr), .gm_data(gm_data),
    .gm_en(gm_en), .gm_err(gm_err), .done(done)
  );

  int n_checks = 0, n_fail = 0;

  // monitor state
  logic [7:0] cap [0:16383];
  int fstart [0:15], flen [0:15], fgap [0:15], fcyc [0:15];
  int nf = 0, wp = 0, idle_run = 0, cyc = 0;
  int done_cnt = 0, done_cyc = -1, last_en_cyc = -1, err_seen = 0;
  bit prev_en = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (gm_err) err_seen++;
    if (gm_en) begin
      if (!prev_en) begin
        fstart[nf] = wp; fcyc[nf] = cyc; fgap[nf] = idle_run;
      end
      if (wp < 16384) cap[wp] = gm_data;
      wp++;
      last_en_cyc = cyc;
      idle_run = 0;
    end else begin
      if (prev_en) begin
        flen[nf] = wp - fstart[nf];
        if (nf < 15) nf++;
      end
      idle_run++;
    end
    prev_en = gm_en;
  end

  task automatic clear_mon();
    nf = 0; wp = 0; idle_run = 0; done_cnt = 0; done_cyc = -1;
    last_en_cyc = -1; err_seen = 0;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected frame image
  logic [7:0] eb [0:4095];
  int elen, e_hdr_end, e_pay_end, e_pad_end;

  function automatic int next_len(int cur, int st, int mx);
    return (cur + st > mx) ? 0 : cur + st;
  endfunction

  task automatic build(int plen, bit pad, bit vl);
    logic [31:0] c;
    int n = 0;
    for (int i = 0; i < 7; i++) eb[n++] = 8'h55;
    eb[n++] = 8'hD5;
    for (int i = 5; i >= 0; i--) eb[n++] = dst_addr[8*i +: 8];
    for (int i = 5; i >= 0; i--) eb[n++] = src_addr[8*i +: 8];
    if (vl) begin
      eb[n++] = 8'h81; eb[n++] = 8'h00;
      eb[n++] = vlan_tci[15:8]; eb[n++] = vlan_tci[7:0];
    end
    eb[n++] = 8'(plen >> 8); eb[n++] = 8'(plen);
    e_hdr_end = n;
    for (int i = 0; i < plen; i++) eb[n++] = 8'(i);
    e_pay_end = n;
    if (pad) while (n - 8 < 60) eb[n++] = 8'h00;
    e_pad_end = n;
    c = 32'hFFFFFFFF;
    for (int i = 8; i < e_pad_end; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ eb[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    c = ~c;
    for (int i = 0; i < 4; i++) eb[n++] = c[8*i +: 8];
    elen = n;
  endtask

  task automatic cmp_region(int f, int lo, int hi, string req, string nm);
    int bad = 0, act = 0, exp = 0;
    for (int i = lo; i < hi; i++)
      if (cap[fstart[f] + i] !== eb[i]) begin
        if (bad == 0) begin act = int'(cap[fstart[f] + i]); exp = int'(eb[i]); end
        bad++;
      end
    check(bad == 0, req, $sformatf("frame %0d %s first bad byte", f, nm), act, exp);
  endtask

  task automatic verify_frames(int n, int l0, int st, int mx, bit pad, bit vl);
    int plen = l0;
    check(nf == n, "R2", "frame count", nf, n);
    check(err_seen == 0, "R1", "error line raised", err_seen, 0);
    for (int f = 0; f < n && f < nf; f++) begin
      build(plen, pad, vl);
      check(flen[f] == elen, pad ? "R7" : "R6", $sformatf("frame %0d length", f), flen[f], elen);
      if (flen[f] == elen) begin
        cmp_region(f, 0, 8, "R3", "preamble");
        cmp_region(f, 8, e_hdr_end, "R4", "header");
        cmp_region(f, e_hdr_end, e_pay_end, "R5", "payload");
        if (e_pad_end > e_pay_end) cmp_region(f, e_pay_end, e_pad_end, "R7", "pad");
        cmp_region(f, e_pad_end, elen, "R8", "fcs");
      end
      plen = next_len(plen, st, mx);
    end
    check(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
    check(done_cyc == last_en_cyc, "R12", "done cycle vs last byte", done_cyc, last_en_cyc);
  endtask

  task automatic run_gen(int n, int l0, int st, int mx, int gap, bit pad, bit vl, bit pe);
    int t = 0;
    @(negedge clk);
    clear_mon();
    frame_count = 16'(n); len_first = 11'(l0); len_step = 11'(st);
    len_max = 11'(mx); gap_bytes = 8'(gap); pad_en = pad; vlan_en = vl;
    pause_en = pe;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == 0 && t < 30000) begin @(negedge clk); t++; end
    if (done_cnt == 0) check(1'b0, "R12", "done never seen", 0, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(gm_en == 1'b0 && done == 1'b0 && gm_err == 1'b0, "R1", "outputs in reset",
          {gm_en, done, gm_err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(gm_en == 1'b0 && done == 1'b0, "R1", "idle after reset", {gm_en, done}, 0);
  endtask

  task automatic t_basic();
    run_gen(3, 100, 50, 1500, 12, 1'b1, 1'b0, 1'b0);
    verify_frames(3, 100, 50, 1500, 1'b1, 1'b0);
    for (int f = 1; f < 3; f++)
      check(fgap[f] == 12, "R9", $sformatf("gap before frame %0d", f), fgap[f], 12);
  endtask

  task automatic t_wrap();
    run_gen(5, 40, 30, 100, 3, 1'b0, 1'b0, 1'b0);
    verify_frames(5, 40, 30, 100, 1'b0, 1'b0);
    check(flen[3] == 8 + 14 + 0 + 4, "R6", "wrapped frame unpadded length", flen[3], 26);
    check(fgap[4] == 3, "R9", "short gap", fgap[4], 3);
  endtask

  task automatic t_vlan_pad();
    vlan_tci = 16'hA123;
    run_gen(2, 10, 5, 100, 4, 1'b1, 1'b1, 1'b0);
    verify_frames(2, 10, 5, 100, 1'b1, 1'b1);
  endtask

  task automatic t_zero();
    @(negedge clk);
    clear_mon();
    frame_count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R12", "done after zero-count start", done, 1);
    repeat (40) @(negedge clk);
    check(nf == 0 && wp == 0, "R2", "bytes sent for zero count", wp, 0);
    check(done_cnt == 1, "R12", "zero-count done pulses", done_cnt, 1);
  endtask

  task automatic t_pause();
    int drop_cyc = 0;
    fork
      run_gen(3, 50, 0, 100, 5, 1'b1, 1'b0, 1'b1);
      begin
        wait (wp >= 20);
        @(negedge clk);
        pause_req = 1'b1;
        repeat (120) @(negedge clk);
        drop_cyc = cyc;
        pause_req = 1'b0;
      end
    join
    verify_frames(3, 50, 0, 100, 1'b1, 1'b0);
    check(fcyc[1] > drop_cyc, "R10", "second frame start after release", fcyc[1], drop_cyc + 1);
    check(fgap[1] > 5, "R10", "held gap longer than programmed", fgap[1], 6);
    check(fgap[2] == 5, "R10", "gap after release", fgap[2], 5);
  endtask

  task automatic t_ignore();
    fork
      run_gen(3, 50, 0, 100, 5, 1'b1, 1'b0, 1'b0);
      begin
        wait (wp >= 20);
        @(negedge clk);
        pause_req = 1'b1;
        repeat (120) @(negedge clk);
        pause_req = 1'b0;
      end
    join
    verify_frames(3, 50, 0, 100, 1'b1, 1'b0);
    check(fgap[1] == 5, "R11", "gap with pause disabled", fgap[1], 5);
    check(fgap[2] == 5, "R11", "second gap with pause disabled", fgap[2], 5);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_vlan_pad();
    t_zero();
    t_pause();
    t_ignore();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule